// File: doc/BRIEF.md
# Power Mode and Clock Divider Controller

This block holds one 8-bit control register. Software uses it to switch the supply domains of a small controller on and off, and to set the rate at which the processor core is clocked. A one-cycle write strobe with a data byte loads the register. The current value is always visible on a read-data port. Five enable outputs follow the register: precision low-frequency input, crystal circuit, PLL, peripheral group and core.

The block enforces a dependency order on power-down. The PLL can only be stopped in the same write that also stops the peripherals and the core. The peripherals can only be stopped in a write that also stops the core. A write that breaks these rules keeps the protected bits as they were, and the rest of that write still takes effect. A wake-up event sets the PLL, peripheral and core bits back to 1 in hardware.

The low three bits of the register select the core clock rate. The block produces a one-cycle clock-enable pulse once every 2^n base cycles. A new rate is taken up only at the end of the current period. While the core is off, the pulse is held low and the counter is held at zero.

Top module: `pwr_clkdiv_ctrl`

## Requirements
- R1: After reset the register reads 0x79. The enables are low-frequency input 0, crystal 1, PLL 1, peripherals 1, core 1. The core clock enable pulses every 2 base cycles.
- R2: The register's bit 7 drives `lfin_en` and bit 6 drives `xtal_en`. Both take any written value directly, and a write is visible on `bus_rdata` in the cycle after the strobe.
- R3: The PLL bit (bit 5) can be cleared only by a write that also clears bit 4 and bit 3. Otherwise the PLL bit keeps its previous value.
- R4: The peripheral bit (bit 4) can be cleared only by a write that also clears bit 3. Otherwise the peripheral bit keeps its previous value.
- R5: A wake-up event sets bits 5, 4 and 3 to 1 in the next cycle, with or without a write.
- R6: When a wake-up and a write fall in the same cycle, bits 5:3 become 1. Bits 7:6 and 2:0 take the written values.
- R7: After the core bit is cleared, `core_en` stays high for one more cycle and then drops. When the core bit is set, `core_en` rises in the same cycle.
- R8: With divider code n in bits 2:0, `core_clk_en` is high for one base cycle in every 2^n cycles. Code 0 means every cycle and code 7 means every 128 cycles.
- R9: A divider change takes effect only at the next period boundary. The period running when the code is written completes at its old length.
- R10: While `core_en` is low, `core_clk_en` stays low. In the first cycle in which `core_en` is high again, `core_clk_en` pulses, because the counter restarts from zero.
- R11: A write whose power-down bits are refused still applies all of its other bits, including the divider code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register value |
| wake_evt | input | 1 | Wake-up event, one cycle high |
| lfin_en | output | 1 | Precision low-frequency input enable |
| xtal_en | output | 1 | Crystal circuit enable |
| pll_en | output | 1 | PLL enable |
| periph_en | output | 1 | Peripheral group enable |
| core_en | output | 1 | Core enable, falling one cycle late |
| core_clk_en | output | 1 | Core clock-enable pulse |

## Verification
The register rules are tried with a chain of writes covering every pattern of bits 5:3:
- Legal full shutdown, which tells the dependency rule apart from an unconditional write.
- PLL-only clear and peripheral-only clear, which separate the two guard rules from each other.
- Mixed cases where only one of the two guards refuses.

Wake-up is applied alone and together with a write, which distinguishes the priority on bits 5:3 from the written bits 7:6 and 2:0. The divider is measured at codes 0, 1, 2, 3, 5 and 7, which separates the exponent from an off-by-one count. A switch from 128 down to 1 mid-period shows whether the old period is cut short. A core power-down and wake show the one-cycle delay on `core_en` and the restart of the counter.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int DIV_W = 3;

  typedef struct packed {
    logic             lfin;
    logic             xtal;
    logic             pll;
    logic             periph;
    logic             core;
    logic [DIV_W-1:0] div;
  } pmc_ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h79;

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [7:0] wdata,
  input  logic      wake,
  output pmc_ctrl_t ctrl_q
);

  pmc_ctrl_t wr_val;
  pmc_ctrl_t ctrl_d;
  logic      ctrl_en;

  assign wr_val  = pmc_ctrl_t'(wdata);
  assign ctrl_en = wr | wake;

  // Next-state: write with dependency guards, then wake-up override
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d = wr_val;
      if (!wr_val.pll && (wr_val.periph || wr_val.core))
        ctrl_d.pll = ctrl_q.pll;
      if (!wr_val.periph && wr_val.core)
        ctrl_d.periph = ctrl_q.periph;
    end
    if (wake) begin
      ctrl_d.pll    = 1'b1;
      ctrl_d.periph = 1'b1;
      ctrl_d.core   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= pmc_ctrl_t'(CTRL_RST);
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // R3: refused PLL clear leaves the PLL bit set
  p_pll_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wake && !wdata[5] && (wdata[4] || wdata[3]) && ctrl_q.pll) |=> ctrl_q.pll);

  // R4: refused peripheral clear leaves the peripheral bit set
  p_periph_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wake && !wdata[4] && wdata[3] && ctrl_q.periph) |=> ctrl_q.periph);

  // R5: wake-up restores the three active-mode bits
  p_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (ctrl_q.pll && ctrl_q.periph && ctrl_q.core));

  // R6: the divider field still follows a write during wake-up
  p_wake_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wake) |=> (ctrl_q.div == $past(wdata[2:0])));

endmodule

// File: rtl/pmc_core_gate.sv
module pmc_core_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req,
  output logic core_en
);

  logic dly_q;
  logic dly_d;

  assign dly_d = core_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= 1'b1;
    else        dly_q <= dly_d;
  end

  // Falling edge delayed by one cycle, rising edge immediate
  assign core_en = core_req | dly_q;

  // R7: the enable survives the cycle in which the request falls
  p_core_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_req) |-> core_en);

  // R7: and is gone one cycle later unless the request came back
  p_core_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_req) |=> (!core_en || core_req));

endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div #(
  parameter int CODE_W   = 3,
  parameter int CODE_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim;
  logic              wrap;
  logic              load;

  assign lim  = (CNT_W'(1) << code_q) - CNT_W'(1);
  assign wrap = (cnt_q == lim);
  assign load = !run || wrap;

  always_comb begin
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= CODE_W'(CODE_RST);
    end else begin
      cnt_q <= cnt_d;
      if (load) code_q <= code;
    end
  end

  assign tick = run && (cnt_q == '0);

  // R8: a pulse is a single cycle wide unless the rate is full
  p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code_q != '0) |=> !tick);

  // R9: the active code only changes at a period boundary
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(code_q));

  // R10: the counter restarts at zero when the core returns
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> tick);

endmodule

// File: rtl/pwr_clkdiv_ctrl.sv
module pwr_clkdiv_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wake_evt,
  output logic       lfin_en,
  output logic       xtal_en,
  output logic       pll_en,
  output logic       periph_en,
  output logic       core_en,
  output logic       core_clk_en
);

  localparam int DIV_RST = int'(CTRL_RST[DIV_W-1:0]);

  logic      rst_i_n;
  pmc_ctrl_t ctrl;
  logic      core_on;

  pmc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pmc_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .wake   (wake_evt),
    .ctrl_q (ctrl)
  );

  pmc_core_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .core_req (ctrl.core),
    .core_en  (core_on)
  );

  pmc_clk_div #(
    .CODE_W   (DIV_W),
    .CODE_RST (DIV_RST)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (core_on),
    .code  (ctrl.div),
    .tick  (core_clk_en)
  );

  assign bus_rdata = ctrl;
  assign lfin_en   = ctrl.lfin;
  assign xtal_en   = ctrl.xtal;
  assign pll_en    = ctrl.pll;
  assign periph_en = ctrl.periph;
  assign core_en   = core_on;

endmodule

// File: tb/test_pwr_clkdiv_ctrl.sv
module test_pwr_clkdiv_ctrl;

  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wake_evt;
  logic       lfin_en, xtal_en, pll_en, periph_en, core_en, core_clk_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwr_clkdiv_ctrl i_pwr_clkdiv_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wake_evt    (wake_evt),
    .lfin_en     (lfin_en),
    .xtal_en     (xtal_en),
    .pll_en      (pll_en),
    .periph_en   (periph_en),
    .core_en     (core_en),
    .core_clk_en (core_clk_en)
  );

  // {wr, wake, wdata, expected register}
  localparam int NVEC = 14;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'hF9, 8'hF9},
    {1'b1, 1'b0, 8'hF3, 8'hF3},
    {1'b1, 1'b0, 8'h03, 8'h03},
    {1'b1, 1'b1, 8'h00, 8'h38},
    {1'b1, 1'b0, 8'h20, 8'h20},
    {1'b1, 1'b0, 8'h18, 8'h38},
    {1'b1, 1'b0, 8'h08, 8'h38},
    {1'b1, 1'b0, 8'h27, 8'h27},
    {1'b1, 1'b0, 8'h10, 8'h30},
    {1'b1, 1'b0, 8'h48, 8'h78},
    {1'b1, 1'b1, 8'hC0, 8'hF8},
    {1'b1, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h38},
    {1'b0, 1'b0, 8'hFF, 8'h38}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:          return "R2";
      2, 5, 8, 11:   return "R3";
      4, 6, 7:       return "R4";
      3, 10:         return "R6";
      9:             return "R11";
      default:       return "R5";
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] d);
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic sync_pulse();
    int g = 0;
    while (!core_clk_en && g < 400) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic gap(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!core_clk_en && k < 400);
  endtask

  task automatic measure(string tag, int exp);
    int k;
    repeat (140) @(negedge clk);
    sync_pulse();
    gap(k);
    chk(tag, k, exp);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    rst_n     = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
    wake_evt  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", int'(bus_rdata), 'h79);
    chk("R1", int'({lfin_en, xtal_en, pll_en, periph_en, core_en}), 'b01111);
    sync_pulse();
    gap(k);
    chk("R1", k, 2);

    // Vector walk over the register rules
    for (int i = 0; i < NVEC; i++) begin
      bus_wr    = VEC[i][17];
      wake_evt  = VEC[i][16];
      bus_wdata = VEC[i][15:8];
      @(negedge clk);
      bus_wr   = 1'b0;
      wake_evt = 1'b0;
      chk(tag_of(i), int'(bus_rdata), int'(VEC[i][7:0]));
      chk("R2", int'({lfin_en, xtal_en, pll_en, periph_en}), int'(VEC[i][7:4]));
    end

    // R7: core power-down with divider code 2 staged
    wr_reg(8'h32);
    chk("R7", int'(bus_rdata), 'h32);
    chk("R7", int'(core_en), 1);
    @(negedge clk);
    chk("R7", int'(core_en), 0);
    // R10: no pulses while the core is off
    for (int j = 0; j < 6; j++) begin
      chk("R10", int'(core_clk_en), 0);
      @(negedge clk);
    end
    // R10/R7: wake-up restarts core and counter at once
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
    chk("R5", int'(bus_rdata), 'h3A);
    chk("R7", int'(core_en), 1);
    chk("R10", int'(core_clk_en), 1);
    gap(k);
    chk("R8", k, 4);

    // R8: period for several codes
    wr_reg(8'h38); measure("R8", 1);
    wr_reg(8'h3B); measure("R8", 8);
    wr_reg(8'h3F); measure("R8", 128);

    // R9: switch from 128 to full rate right after a pulse
    sync_pulse();
    bus_wr    = 1'b1;
    bus_wdata = 8'h38;
    gap(k);
    bus_wr = 1'b0;
    chk("R9", k, 128);
    gap(k);
    chk("R9", k, 1);

    // R11: refused power-down still applies the divider field
    wr_reg(8'h0D);
    chk("R11", int'(bus_rdata), 'h3D);
    measure("R11", 32);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule